// File: doc/BRIEF.md
# Triggered Signal Capture Recorder

This block watches a small group of trigger inputs and, whenever a selected trigger condition is met, takes a snapshot of a wide group of probed signals and pushes it as one record into an internal queue. A 2-bit mode input picks the condition: rising edge, falling edge, any change, or level high. The mode applies to every trigger bit, and the per-bit results are OR-combined, so one qualifying trigger is enough to capture.

Records leave through a streaming valid/ready output in the order they were captured. When the queue is full, a new capture is discarded and a sticky overflow flag records the loss. The flag stays set until software or surrounding logic pulses a synchronous clear.

Top module: `sigCaptureRecorder`

## Requirements
- R1: While reset is asserted and after it is released, outValid and overflow read 0. The first clock edge after release writes no record in any mode and only loads the previous-trigger register, so triggers that were already high at release give no spurious capture.
- R2: With trigMode = 2'b00 (rising), a record is written at a clock edge where some trigger bit is 1 and was 0 at the previous edge. A trigger held high captures only once.
- R3: With trigMode = 2'b01 (falling), a record is written at a clock edge where some trigger bit is 0 and was 1 at the previous edge. A 0 to 1 change captures nothing.
- R4: With trigMode = 2'b10 (any change), a record is written at every edge where some trigger bit differs from its value at the previous edge, in either direction.
- R5: With trigMode = 2'b11 (level), a record is written at every clock edge where any trigger bit is 1.
- R6: The per-bit conditions are OR-combined, and at most one record is written per clock edge however many trigger bits qualify.
- R7: A record is the value of probeIn at the capturing clock edge. Records are delivered on outData in capture order.
- R8: outValid is 1 whenever at least one record is held. A record is removed only at an edge where outValid and outReady are both 1. While outValid is 1 and outReady is 0, outValid stays 1 and outData holds its value.
- R9: When a capture fires while the queue is full, the record is dropped and overflow is set. overflow stays 1 until an edge with clearOvf = 1. If a drop and a clear fall on the same edge, the flag ends up set.
- R10: The queue holds exactly DEPTH records (default 16), and the fill level never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| trigIn | input | TRIG_W | Trigger inputs |
| trigMode | input | 2 | Trigger condition select |
| probeIn | input | DATA_W | Signals captured into a record |
| clearOvf | input | 1 | Synchronous clear of the overflow flag |
| outReady | input | 1 | Downstream ready for a record |
| outValid | output | 1 | A record is available on outData |
| outData | output | DATA_W | Oldest held record |
| overflow | output | 1 | Sticky flag: a capture was dropped |

## Verification
The hardest state to reach from the ports is the full queue meeting a new capture. The bench holds outReady low and uses level mode with one trigger held high for DEPTH+2 edges, writing a distinct probe value at each edge. That fills every slot in consecutive cycles and forces two drops. Draining afterwards shows that exactly the first DEPTH values survived, in order, and that overflow stays set until the clear pulse. Spurious capture after reset is provoked by holding trigger bits high across the release.

// File: rtl/scr_pkg.sv
package scr_pkg;

  typedef enum logic [1:0] {
    MODE_RISE   = 2'b00,
    MODE_FALL   = 2'b01,
    MODE_CHANGE = 2'b10,
    MODE_LEVEL  = 2'b11
  } trig_mode_e;

  // Strobes from the control module to the storage datapath
  typedef struct packed {
    logic wrEn;   // write probe snapshot at write pointer
    logic rdEn;   // retire record at read pointer
  } scr_strobe_t;

endpackage

// File: rtl/scr_trig_detect.sv
module scr_trig_detect
  import scr_pkg::*;
#(
  parameter int TRIG_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TRIG_W-1:0] trigIn,
  input  trig_mode_e        mode,
  output logic              fire
);

  logic [TRIG_W-1:0] prevTrig;
  logic [TRIG_W-1:0] bitHit;
  logic              armed;

  // prevTrig follows trigIn every edge; the first edge after reset only primes it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevTrig <= '0;
      armed    <= 1'b0;
    end else begin
      prevTrig <= trigIn;
      armed    <= 1'b1;
    end
  end

  for (genvar i = 0; i < TRIG_W; i++) begin : g_cell
    always_comb begin
      unique case (mode)
        MODE_RISE:   bitHit[i] = trigIn[i] & ~prevTrig[i];
        MODE_FALL:   bitHit[i] = ~trigIn[i] & prevTrig[i];
        MODE_CHANGE: bitHit[i] = trigIn[i] ^ prevTrig[i];
        default:     bitHit[i] = trigIn[i];
      endcase
    end
  end

  assign fire = armed & (|bitHit);

endmodule

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_pkg::*;
#(
  parameter int TRIG_W = 4,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TRIG_W-1:0] trigIn,
  input  logic [1:0]        trigMode,
  input  logic              clearOvf,
  input  logic              outReady,
  output scr_strobe_t       stb,
  output logic              outValid,
  output logic              overflow,
  output logic [CNT_W-1:0]  fill
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic fire;
  logic isFull;
  logic dropRec;

  scr_trig_detect #(.TRIG_W(TRIG_W)) u_detect (
    .clk    (clk),
    .rstN   (rstN),
    .trigIn (trigIn),
    .mode   (trig_mode_e'(trigMode)),
    .fire   (fire)
  );

  assign isFull   = (fill == FULL_CNT);
  assign outValid = (fill != '0);

  always_comb begin
    stb.wrEn = fire & ~isFull;
    stb.rdEn = outValid & outReady;
    dropRec  = fire & isFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fill <= '0;
    end else begin
      unique case ({stb.wrEn, stb.rdEn})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         overflow <= 1'b0;
    else if (dropRec)  overflow <= 1'b1;
    else if (clearOvf) overflow <= 1'b0;
  end

endmodule

// File: rtl/scr_dpath.sv
module scr_dpath
  import scr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  scr_strobe_t       stb,
  input  logic [DATA_W-1:0] probeIn,
  output logic [DATA_W-1:0] outData
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] slotMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (stb.wrEn) slotMem[wrPtr] <= probeIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.wrEn) wrPtr <= nextPtr(wrPtr);
      if (stb.rdEn) rdPtr <= nextPtr(rdPtr);
    end
  end

  assign outData = slotMem[rdPtr];

endmodule

// File: rtl/sigCaptureRecorder.sv
module sigCaptureRecorder
  import scr_pkg::*;
#(
  parameter int TRIG_W = 4,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TRIG_W-1:0] trigIn,
  input  logic [1:0]        trigMode,
  input  logic [DATA_W-1:0] probeIn,
  input  logic              clearOvf,
  input  logic              outReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              overflow
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  scr_strobe_t      stb;
  logic [CNT_W-1:0] fill;

  scr_ctrl #(.TRIG_W(TRIG_W), .DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .trigIn   (trigIn),
    .trigMode (trigMode),
    .clearOvf (clearOvf),
    .outReady (outReady),
    .stb      (stb),
    .outValid (outValid),
    .overflow (overflow),
    .fill     (fill)
  );

  scr_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .probeIn (probeIn),
    .outData (outData)
  );

endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
  parameter int TRIG_W = 4,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic [TRIG_W-1:0] trigIn,
  input logic [1:0]        trigMode,
  input logic              clearOvf,
  input logic              outReady,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              overflow,
  input logic [CNT_W-1:0]  fill
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic             seenEdge;
  logic [CNT_W-1:0] levelNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenEdge <= 1'b0;
    else       seenEdge <= 1'b1;
  end

  always_comb levelNext = fill + 1'b1 - {{(CNT_W-1){1'b0}}, (outValid & outReady)};

  // R1: first edge after reset writes nothing
  a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rstN)
    !seenEdge |=> fill == '0);

  // R5: level mode with room writes one record per edge
  a_r5_level_capture: assert property (@(posedge clk) disable iff (!rstN)
    (seenEdge && trigMode == 2'b11 && (|trigIn) && fill != FULL_CNT)
      |=> fill == $past(levelNext));

  // R6: fill moves by at most one per edge
  a_r6_single_write: assert property (@(posedge clk) disable iff (!rstN)
    seenEdge |=> (fill <= $past(fill) + 1'b1));

  // R8: stalled output holds
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R9: overflow is sticky without clear
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !clearOvf) |=> overflow);

  // R9: clear with no drop pending empties the flag
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clearOvf && fill != FULL_CNT) |=> !overflow);

  // R10: bounded fill
  a_r10_bound: assert property (@(posedge clk) disable iff (!rstN)
    fill <= FULL_CNT);

endmodule

bind sigCaptureRecorder scr_checker #(
  .TRIG_W(TRIG_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .trigIn   (trigIn),
  .trigMode (trigMode),
  .clearOvf (clearOvf),
  .outReady (outReady),
  .outValid (outValid),
  .outData  (outData),
  .overflow (overflow),
  .fill     (fill)
);

// File: tb/tb_sigCaptureRecorder.sv
`timescale 1ns/1ps
module tb_sigCaptureRecorder;

  localparam int TRIG_W = 4;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 16;

  logic              clk = 1'b0;
  logic              rstN;
  logic [TRIG_W-1:0] trigIn;
  logic [1:0]        trigMode;
  logic [DATA_W-1:0] probeIn;
  logic              clearOvf;
  logic              outReady;
  logic              outValid;
  logic [DATA_W-1:0] outData;
  logic              overflow;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sigCaptureRecorder #(.TRIG_W(TRIG_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .trigMode(trigMode),
    .probeIn(probeIn), .clearOvf(clearOvf), .outReady(outReady),
    .outValid(outValid), .outData(outData), .overflow(overflow)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic stepIn(input logic [TRIG_W-1:0] t, input logic [DATA_W-1:0] p);
    @(negedge clk);
    trigIn  = t;
    probeIn = p;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic popExpect(input string req, input logic [DATA_W-1:0] exp);
    @(negedge clk);
    check({req, " valid"}, 32'(outValid), 32'd1);
    check({req, " data"}, 32'(outData), 32'(exp));
    outReady = 1'b1;
    @(posedge clk);
    #1 outReady = 1'b0;
  endtask

  task automatic expectEmpty(input string req);
    @(negedge clk);
    check({req, " empty"}, 32'(outValid), 32'd0);
  endtask

  // R1: reset state, no spurious edge after release
  task automatic testReset();
    rstN = 1'b0; trigIn = 4'b1010; trigMode = 2'b00; probeIn = 16'hDEAD;
    clearOvf = 1'b0; outReady = 1'b0;
    idle(3);
    check("R1 valid in reset", 32'(outValid), 32'd0);
    check("R1 overflow in reset", 32'(overflow), 32'd0);
    rstN = 1'b1;
    idle(4);
    check("R1 no spurious rise", 32'(outValid), 32'd0);
    check("R1 overflow after release", 32'(overflow), 32'd0);
    stepIn(4'b0000, 16'h0);
    idle(2);
    expectEmpty("R1 falling to zero in rise mode");
  endtask

  // R2: rising edge, held high captures once
  task automatic testRise();
    trigMode = 2'b00;
    stepIn(4'b0100, 16'h1111);
    stepIn(4'b0100, 16'h2222);
    idle(3);
    stepIn(4'b0000, 16'h3333);
    idle(2);
    popExpect("R2 rise", 16'h1111);
    expectEmpty("R2 held high once");
  endtask

  // R3: falling edge only
  task automatic testFall();
    trigMode = 2'b01;
    stepIn(4'b0001, 16'hA0A0);
    idle(2);
    expectEmpty("R3 rise ignored");
    stepIn(4'b0000, 16'hB0B0);
    stepIn(4'b0000, 16'hC0C0);
    idle(2);
    popExpect("R3 fall", 16'hB0B0);
    expectEmpty("R3 single fall");
  endtask

  // R4: any change, both directions
  task automatic testChange();
    trigMode = 2'b10;
    stepIn(4'b1000, 16'h0C01);
    stepIn(4'b1000, 16'h0C02);
    idle(2);
    stepIn(4'b0000, 16'h0C03);
    stepIn(4'b0000, 16'h0C04);
    idle(2);
    popExpect("R4 change up", 16'h0C01);
    popExpect("R4 change down", 16'h0C03);
    expectEmpty("R4 no extra");
  endtask

  // R5 and R7: level mode captures each edge in order
  task automatic testLevel();
    trigMode = 2'b11;
    stepIn(4'b0010, 16'h5001);
    stepIn(4'b0010, 16'h5002);
    stepIn(4'b0010, 16'h5003);
    stepIn(4'b0000, 16'h5004);
    idle(2);
    popExpect("R5 R7 level 0", 16'h5001);
    popExpect("R5 R7 level 1", 16'h5002);
    popExpect("R5 R7 level 2", 16'h5003);
    expectEmpty("R5 stops when low");
  endtask

  // R6: several bits at once give one record
  task automatic testOrCombine();
    trigMode = 2'b00;
    stepIn(4'b1111, 16'h6600);
    stepIn(4'b1111, 16'h6601);
    idle(2);
    stepIn(4'b0000, 16'h6602);
    stepIn(4'b0001, 16'h6603);
    stepIn(4'b0000, 16'h6604);
    idle(2);
    popExpect("R6 multi bit one record", 16'h6600);
    popExpect("R6 single bit", 16'h6603);
    expectEmpty("R6 no duplicates");
  endtask

  // R8: stall holds data and valid
  task automatic testStall();
    trigMode = 2'b00;
    stepIn(4'b0001, 16'h7777);
    stepIn(4'b0000, 16'h0000);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R8 stall valid", 32'(outValid), 32'd1);
      check("R8 stall data", 32'(outData), 32'h7777);
    end
    popExpect("R8 pop after stall", 16'h7777);
    expectEmpty("R8 removed once");
  endtask

  // R9 and R10: fill, drop, sticky flag, clear
  task automatic testOverflow();
    trigMode = 2'b11;
    outReady = 1'b0;
    for (int i = 0; i < DEPTH + 2; i++) stepIn(4'b0001, 16'h100 + 16'(i));
    stepIn(4'b0000, 16'h0);
    @(negedge clk);
    check("R9 overflow set", 32'(overflow), 32'd1);
    idle(3);
    check("R9 overflow sticky", 32'(overflow), 32'd1);
    for (int i = 0; i < DEPTH; i++) popExpect("R10 depth record", 16'h100 + 16'(i));
    expectEmpty("R10 dropped records absent");
    check("R9 sticky after drain", 32'(overflow), 32'd1);
    @(negedge clk);
    clearOvf = 1'b1;
    @(posedge clk);
    #1 clearOvf = 1'b0;
    @(negedge clk);
    check("R9 cleared", 32'(overflow), 32'd0);
  endtask

  initial begin
    testReset();
    testRise();
    testFall();
    testChange();
    testLevel();
    testOrCombine();
    testStall();
    testOverflow();
    idle(2);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule